// File: doc/BRIEF.md
# Low-Power Seconds Counter with Alarm

This peripheral keeps wall-clock time in a slow, free-running clock domain that is asynchronous to the bus. A 32-bit whole-seconds counter is fed by a sub-second counter that advances once per slow-clock period and carries into the seconds count when it wraps. An alarm comparator sets a status flag when the seconds count equals the programmed alarm value. That flag drives a level interrupt and a wakeup request, each behind its own enable.

Counting is locked until software completes a two-step unlock. A magic key goes into the glitch-detect register. An init-exit command moves the block to a non-valid state, and a second command that also sets the non-valid-exit and low-power-enable bits moves it to the valid state, where counting begins. Bus writes land in bus-clock shadow registers. A toggle request/acknowledge handshake carries a coherent snapshot of them into the slow domain, so that each write takes effect on the third slow-clock edge after it is launched. Counter and status reads come from a bus-side mirror of the slow-domain state that updates only when two consecutive samples agree.

Top module: `lp_secure_rtc`

## Requirements
- R1: After reset every register address reads zero, and `irq` and `wake` are low.
- R2: Byte addresses 0x08 (alarm), 0x10 (control) and 0x18 (glitch key) read back what was written. Control reads back only bits 3, 4, 7, 11, 14 and 15. Unmapped addresses read zero.
- R3: Writing control with bit 15 (init exit) and bit 11 (non-secure access) set, while the key register holds 0x41736166, leaves the init state and sets status bit 15. No other transition is possible from init, and the counters hold outside the valid state.
- R4: From the non-valid state, control bits 15, 14, 11 and 3 together with the key 0x41736166 enter the valid state and set status bit 14. With any other key the block stays in the non-valid state and does not count.
- R5: In the valid state, the sub-second count (address 0x04, SUB_W bits) advances on every slow-clock edge. When it wraps it increments the seconds count at address 0x00.
- R6: A write to address 0x00 loads the seconds count and clears the sub-second count.
- R7: While valid, a seconds count equal to the alarm register sets status bit 3.
- R8: `irq` equals status bit 3 AND control bit 7. `wake` equals status bit 3 AND control bit 4.
- R9: Status bits clear only where a 1 is written to address 0x14. Zero bits leave status unchanged.
- R10: A bus write reaches the slow domain no later than three slow-clock periods after its launch, and not before.
- R11: Writes issued back to back while a transfer is in flight are not lost. The latest shadow values and all pending clears reach the slow domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-side clock |
| slow_clk | input | 1 | Slow low-power counting clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously per domain |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| wr_addr | input | 5 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read byte address |
| rd_data | output | 32 | Read data for rd_addr |
| irq | output | 1 | Level alarm interrupt |
| wake | output | 1 | Level wakeup request |

## Verification
The hardest state to reach is an alarm match with both enables toggled while the block is counting. Getting there means performing the full unlock, including failed attempts with the wrong key, and then waiting out whole seconds. The bench shrinks the sub-second counter to four bits so that a second lasts sixteen slow periods. It loads the seconds count just below the alarm value and issues bursts of back-to-back writes, which load the handshake. The crossing latency is observed by sampling `irq` in the bus cycle right after an enable write and again three slow periods later.

// File: rtl/slow_rtc_pkg.sv
package slow_rtc_pkg;

  localparam logic [31:0] GLITCH_KEY = 32'h4173_6166;

  localparam logic [4:0] A_SEC = 5'h00;
  localparam logic [4:0] A_SUB = 5'h04;
  localparam logic [4:0] A_ALM = 5'h08;
  localparam logic [4:0] A_CTL = 5'h10;
  localparam logic [4:0] A_STS = 5'h14;
  localparam logic [4:0] A_KEY = 5'h18;

  typedef enum logic [1:0] {
    LS_INIT     = 2'd0,
    LS_NONVALID = 2'd1,
    LS_VALID    = 2'd2
  } lp_state_e;

  typedef struct packed {
    logic inx;   // bit 15
    logic nvx;   // bit 14
    logic nsa;   // bit 11
    logic aie;   // bit 7
    logic wke;   // bit 4
    logic lpen;  // bit 3
  } ctl_t;

  typedef struct packed {
    logic ind;   // bit 15
    logic nvd;   // bit 14
    logic alm;   // bit 3
  } sts_t;

  typedef struct packed {
    ctl_t        ctl;
    logic [31:0] alm;
    logic [31:0] key;
    logic        set_en;
    logic [31:0] set_val;
    sts_t        clr;
  } xfer_t;

  function automatic ctl_t word_to_ctl(input logic [31:0] w);
    ctl_t c;
    c.inx  = w[15];
    c.nvx  = w[14];
    c.nsa  = w[11];
    c.aie  = w[7];
    c.wke  = w[4];
    c.lpen = w[3];
    return c;
  endfunction

  function automatic logic [31:0] ctl_to_word(input ctl_t c);
    logic [31:0] w;
    w     = '0;
    w[15] = c.inx;
    w[14] = c.nvx;
    w[11] = c.nsa;
    w[7]  = c.aie;
    w[4]  = c.wke;
    w[3]  = c.lpen;
    return w;
  endfunction

  function automatic sts_t word_to_sts(input logic [31:0] w);
    sts_t s;
    s.ind = w[15];
    s.nvd = w[14];
    s.alm = w[3];
    return s;
  endfunction

  function automatic logic [31:0] sts_to_word(input sts_t s);
    logic [31:0] w;
    w     = '0;
    w[15] = s.ind;
    w[14] = s.nvd;
    w[3]  = s.alm;
    return w;
  endfunction

endpackage

// File: rtl/slow_rtc_rst_sync.sv
module slow_rtc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/slow_rtc_sync2.sv
module slow_rtc_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/slow_rtc_bus.sv
module slow_rtc_bus
  import slow_rtc_pkg::*;
#(
  parameter int SUB_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [4:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [4:0]       rd_addr,
  output logic [31:0]      rd_data,
  input  logic             ack_tgl,
  input  logic [31:0]      sec_s,
  input  logic [SUB_W-1:0] sub_s,
  input  sts_t             sts_s,
  output logic             req_tgl,
  output xfer_t            flight
);
  localparam int SNAP_W = 32 + SUB_W + 3;

  ctl_t              ctl_q, ctl_d;
  logic [31:0]       alm_q, alm_d;
  logic [31:0]       key_q, key_d;
  logic              set_en_q, set_en_d;
  logic [31:0]       set_val_q, set_val_d;
  sts_t              clr_q, clr_d;
  logic              dirty_q, dirty_d;
  logic              req_q, req_d;
  xfer_t             flight_q, flight_d;
  logic              ack_s;
  logic              busy, launch;
  logic [SNAP_W-1:0] snap_cur, snap_a_q, snap_b_q, mir_q, mir_d;
  logic [31:0]       mir_sec;
  logic [SUB_W-1:0]  mir_sub;
  sts_t              mir_sts;

  slow_rtc_sync2 #(.W(1)) u_ack_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ack_tgl),
    .q     (ack_s)
  );

  assign busy     = req_q ^ ack_s;
  assign launch   = dirty_q & ~busy;
  assign snap_cur = {sec_s, sub_s, sts_s};

  // next state: launch a snapshot, then merge this cycle's write
  always_comb begin
    ctl_d     = ctl_q;
    alm_d     = alm_q;
    key_d     = key_q;
    set_en_d  = set_en_q;
    set_val_d = set_val_q;
    clr_d     = clr_q;
    dirty_d   = dirty_q;
    req_d     = req_q;
    flight_d  = flight_q;
    if (launch) begin
      flight_d.ctl     = ctl_q;
      flight_d.alm     = alm_q;
      flight_d.key     = key_q;
      flight_d.set_en  = set_en_q;
      flight_d.set_val = set_val_q;
      flight_d.clr     = clr_q;
      req_d            = ~req_q;
      set_en_d         = 1'b0;
      clr_d            = '0;
      dirty_d          = 1'b0;
    end
    if (wr_en) begin
      unique case (wr_addr)
        A_SEC: begin
          set_en_d  = 1'b1;
          set_val_d = wr_data;
          dirty_d   = 1'b1;
        end
        A_ALM: begin
          alm_d   = wr_data;
          dirty_d = 1'b1;
        end
        A_CTL: begin
          ctl_d   = word_to_ctl(wr_data);
          dirty_d = 1'b1;
        end
        A_STS: begin
          clr_d   = clr_d | word_to_sts(wr_data);
          dirty_d = 1'b1;
        end
        A_KEY: begin
          key_d   = wr_data;
          dirty_d = 1'b1;
        end
        default: ;
      endcase
    end
    mir_d = (snap_a_q == snap_b_q) ? snap_b_q : mir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      alm_q     <= '0;
      key_q     <= '0;
      set_en_q  <= 1'b0;
      set_val_q <= '0;
      clr_q     <= '0;
      dirty_q   <= 1'b0;
      req_q     <= 1'b0;
      flight_q  <= '0;
      snap_a_q  <= '0;
      snap_b_q  <= '0;
      mir_q     <= '0;
    end else begin
      ctl_q     <= ctl_d;
      alm_q     <= alm_d;
      key_q     <= key_d;
      set_en_q  <= set_en_d;
      set_val_q <= set_val_d;
      clr_q     <= clr_d;
      dirty_q   <= dirty_d;
      req_q     <= req_d;
      flight_q  <= flight_d;
      snap_a_q  <= snap_cur;
      snap_b_q  <= snap_a_q;
      mir_q     <= mir_d;
    end
  end

  assign {mir_sec, mir_sub, mir_sts} = mir_q;

  always_comb begin
    unique case (rd_addr)
      A_SEC:   rd_data = mir_sec;
      A_SUB:   rd_data = {{(32-SUB_W){1'b0}}, mir_sub};
      A_ALM:   rd_data = alm_q;
      A_CTL:   rd_data = ctl_to_word(ctl_q);
      A_STS:   rd_data = sts_to_word(mir_sts);
      A_KEY:   rd_data = key_q;
      default: rd_data = '0;
    endcase
  end

  assign req_tgl = req_q;
  assign flight  = flight_q;

  // R11: the snapshot seen by the slow domain must not move mid-handshake
  a_r11_flight_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(flight_q));

  // R6: a seconds write is always latched for the next transfer
  a_r6_set_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_SEC) |=> (set_en_q && set_val_q == $past(wr_data)));
endmodule

// File: rtl/slow_rtc_lp_core.sv
module slow_rtc_lp_core
  import slow_rtc_pkg::*;
#(
  parameter int SUB_W = 15
) (
  input  logic             sclk,
  input  logic             srst_n,
  input  logic             req_tgl,
  input  xfer_t            xfer,
  output logic             ack_tgl,
  output logic [31:0]      sec,
  output logic [SUB_W-1:0] sub,
  output sts_t             sts,
  output logic             irq,
  output logic             wake
);
  localparam logic [SUB_W-1:0] SUB_MAX = {SUB_W{1'b1}};

  logic             req_s;
  logic             seen_q;
  logic             apply;
  ctl_t             ctl_q, ctl_d;
  logic [31:0]      alm_q, alm_d;
  logic [31:0]      key_q, key_d;
  lp_state_e        state_q, state_d;
  logic [31:0]      sec_q, sec_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  sts_t             sts_q, sts_d;
  logic             init_ok, valid_ok;

  slow_rtc_sync2 #(.W(1)) u_req_sync (
    .clk   (sclk),
    .rst_n (srst_n),
    .d     (req_tgl),
    .q     (req_s)
  );

  assign apply = req_s ^ seen_q;

  always_comb begin
    ctl_d   = ctl_q;
    alm_d   = alm_q;
    key_d   = key_q;
    state_d = state_q;
    sec_d   = sec_q;
    sub_d   = sub_q;
    sts_d   = sts_q;
    if (apply) begin
      ctl_d = xfer.ctl;
      alm_d = xfer.alm;
      key_d = xfer.key;
      sts_d = sts_q & ~xfer.clr;
    end
    init_ok  = apply && ctl_d.inx && ctl_d.nsa && (key_d == GLITCH_KEY);
    valid_ok = init_ok && ctl_d.nvx && ctl_d.lpen;
    unique case (state_q)
      LS_INIT: if (init_ok) begin
        state_d   = LS_NONVALID;
        sts_d.ind = 1'b1;
      end
      LS_NONVALID: if (valid_ok) begin
        state_d   = LS_VALID;
        sts_d.nvd = 1'b1;
      end
      default: ;
    endcase
    if (state_q == LS_VALID) begin
      sub_d = sub_q + 1'b1;
      if (sub_q == SUB_MAX) sec_d = sec_q + 32'd1;
      if (sec_q == alm_q) sts_d.alm = 1'b1;
    end
    if (apply && xfer.set_en) begin
      sec_d = xfer.set_val;
      sub_d = '0;
    end
  end

  always_ff @(posedge sclk or negedge srst_n) begin
    if (!srst_n) begin
      seen_q  <= 1'b0;
      ctl_q   <= '0;
      alm_q   <= '0;
      key_q   <= '0;
      state_q <= LS_INIT;
      sec_q   <= '0;
      sub_q   <= '0;
      sts_q   <= '0;
    end else begin
      seen_q  <= req_s;
      ctl_q   <= ctl_d;
      alm_q   <= alm_d;
      key_q   <= key_d;
      state_q <= state_d;
      sec_q   <= sec_d;
      sub_q   <= sub_d;
      sts_q   <= sts_d;
    end
  end

  assign ack_tgl = seen_q;
  assign sec     = sec_q;
  assign sub     = sub_q;
  assign sts     = sts_q;
  assign irq     = sts_q.alm & ctl_q.aie;
  assign wake    = sts_q.alm & ctl_q.wke;

  a_r3_hold_outside_valid: assert property (@(posedge sclk) disable iff (!srst_n)
    (state_q != LS_VALID && !apply) |=> ($stable(sub_q) && $stable(sec_q)));

  a_r5_rollover: assert property (@(posedge sclk) disable iff (!srst_n)
    (state_q == LS_VALID && !apply && sub_q == SUB_MAX)
      |=> (sub_q == '0 && sec_q == $past(sec_q) + 32'd1));

  a_r4_key_required: assert property (@(posedge sclk) disable iff (!srst_n)
    (apply && state_q == LS_NONVALID && xfer.key != GLITCH_KEY)
      |=> state_q == LS_NONVALID);

  a_r4_valid_sticky: assert property (@(posedge sclk) disable iff (!srst_n)
    state_q == LS_VALID |=> state_q == LS_VALID);

  a_r7_alarm_sets: assert property (@(posedge sclk) disable iff (!srst_n)
    (state_q == LS_VALID && sec_q == alm_q) |=> sts_q.alm);
endmodule

// File: rtl/lp_secure_rtc.sv
module lp_secure_rtc
  import slow_rtc_pkg::*;
#(
  parameter int SUB_W = 15
) (
  input  logic        bus_clk,
  input  logic        slow_clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [4:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        irq,
  output logic        wake
);
  logic             bus_rst_n;
  logic             slow_rst_n;
  logic             req_tgl;
  logic             ack_tgl;
  xfer_t            flight;
  logic [31:0]      sec_s;
  logic [SUB_W-1:0] sub_s;
  sts_t             sts_s;

  slow_rtc_rst_sync #(.STAGES(2)) u_bus_rst (
    .clk        (bus_clk),
    .rst_n      (rst_n),
    .rst_n_sync (bus_rst_n)
  );

  slow_rtc_rst_sync #(.STAGES(2)) u_slow_rst (
    .clk        (slow_clk),
    .rst_n      (rst_n),
    .rst_n_sync (slow_rst_n)
  );

  slow_rtc_bus #(.SUB_W(SUB_W)) u_bus (
    .clk     (bus_clk),
    .rst_n   (bus_rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .ack_tgl (ack_tgl),
    .sec_s   (sec_s),
    .sub_s   (sub_s),
    .sts_s   (sts_s),
    .req_tgl (req_tgl),
    .flight  (flight)
  );

  slow_rtc_lp_core #(.SUB_W(SUB_W)) u_core (
    .sclk    (slow_clk),
    .srst_n  (slow_rst_n),
    .req_tgl (req_tgl),
    .xfer    (flight),
    .ack_tgl (ack_tgl),
    .sec     (sec_s),
    .sub     (sub_s),
    .sts     (sts_s),
    .irq     (irq),
    .wake    (wake)
  );
endmodule

// File: tb/lp_secure_rtc_tb.sv
module lp_secure_rtc_tb;
  localparam int BUS_PERIOD  = 10;
  localparam int SLOW_PERIOD = 74;
  localparam logic [31:0] KEY = 32'h4173_6166;

  logic        bus_clk = 1'b0;
  logic        slow_clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [31:0] wr_data;
  logic [4:0]  rd_addr;
  logic [31:0] rd_data;
  logic        irq;
  logic        wake;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(BUS_PERIOD/2) bus_clk = ~bus_clk;
  always #(SLOW_PERIOD/2) slow_clk = ~slow_clk;

  lp_secure_rtc #(.SUB_W(4)) u_dut (
    .bus_clk  (bus_clk),
    .slow_clk (slow_clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .irq      (irq),
    .wake     (wake)
  );

  // {address, write data, expected read-back}
  localparam logic [68:0] VEC [5] = '{
    {5'h18, 32'h1234_5678, 32'h1234_5678},
    {5'h08, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {5'h10, 32'hFFFF_FFFF, 32'h0000_C898},
    {5'h0C, 32'hFFFF_FFFF, 32'h0000_0000},
    {5'h1C, 32'hA5A5_A5A5, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge bus_clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge bus_clk);
    wr_en   = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge bus_clk);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic settle();
    #(14*SLOW_PERIOD);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge bus_clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] v2;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    rd_addr = '0;
    #(3*SLOW_PERIOD);
    @(negedge bus_clk);
    rst_n = 1'b1;
    #(4*SLOW_PERIOD);

    // R1: reset state
    for (int a = 0; a < 7; a++) begin
      rd(5'(a*4), v);
      chk("R1 reset read", v, 32'h0);
    end
    chk("R1 irq low", {31'b0, irq}, 32'h0);
    chk("R1 wake low", {31'b0, wake}, 32'h0);

    // R2: vector table of write/read-back pairs
    for (int i = 0; i < 5; i++) begin
      wr(VEC[i][68:64], VEC[i][63:32]);
      rd(VEC[i][68:64], v);
      chk("R2 readback", v, VEC[i][31:0]);
    end
    settle();
    // R3: all-ones control with a wrong key must not leave init
    rd(5'h14, v);
    chk("R3 no exit without key", v, 32'h0);

    // R3, R11: back-to-back writes, init exit
    wr(5'h10, 32'h0);
    wr(5'h18, KEY);
    wr(5'h10, 32'h0000_8800);
    settle();
    rd(5'h14, v);
    chk("R3 R11 init exit status", v, 32'h0000_8000);
    rd(5'h04, v);
    chk("R3 no counting before valid", v, 32'h0);

    // R4: wrong key blocks the non-valid exit
    wr(5'h18, 32'h0);
    wr(5'h10, 32'h0000_C808);
    settle();
    rd(5'h14, v);
    chk("R4 wrong key stays non-valid", v, 32'h0000_8000);
    rd(5'h04, v);
    chk("R4 wrong key no counting", v, 32'h0);

    // R4: key restored, same control enters valid
    wr(5'h18, KEY);
    settle();
    rd(5'h14, v);
    chk("R4 valid exit status", v, 32'h0000_C000);

    // R9: write-one-to-clear, zeros keep
    wr(5'h14, 32'h0000_4000);
    settle();
    rd(5'h14, v);
    chk("R9 partial clear", v, 32'h0000_8000);
    wr(5'h14, 32'h0000_8000);
    settle();
    rd(5'h14, v);
    chk("R9 full clear", v, 32'h0);

    // R5: sub-second count moves
    rd(5'h04, v);
    #(2*SLOW_PERIOD);
    rd(5'h04, v2);
    chk("R5 sub count advances", {31'b0, (v != v2)}, 32'h1);

    // R6: seconds load
    wr(5'h00, 32'd100);
    #(4*SLOW_PERIOD);
    rd(5'h00, v);
    chk("R6 seconds loaded", v, 32'd100);
    rd(5'h04, v);
    chk("R6 sub cleared on load", {31'b0, (v <= 32'd5)}, 32'h1);

    // R5: rollover into seconds
    #(38*SLOW_PERIOD);
    rd(5'h00, v);
    chk("R5 seconds after rollover", v, 32'd102);

    // R7, R8: alarm match, no enables
    wr(5'h08, 32'd104);
    #(40*SLOW_PERIOD);
    rd(5'h14, v);
    chk("R7 alarm flag", v, 32'h0000_0008);
    chk("R8 irq masked", {31'b0, irq}, 32'h0);
    chk("R8 wake masked", {31'b0, wake}, 32'h0);

    // R8: wakeup enable only
    wr(5'h10, 32'h0000_C818);
    #(5*SLOW_PERIOD);
    chk("R8 wake follows enable", {31'b0, wake}, 32'h1);
    chk("R8 irq still masked", {31'b0, irq}, 32'h0);

    // R10: crossing latency of an interrupt-enable write
    wr(5'h10, 32'h0000_C898);
    chk("R10 not yet applied", {31'b0, irq}, 32'h0);
    #(5 + 3*SLOW_PERIOD + 3);
    chk("R10 applied within three slow periods", {31'b0, irq}, 32'h1);

    // R9: zero write keeps the alarm flag
    wr(5'h14, 32'h0);
    settle();
    rd(5'h14, v);
    chk("R9 zero write keeps flag", v, 32'h0000_0008);
    chk("R8 irq while flagged", {31'b0, irq}, 32'h1);

    // R9, R8: clear the alarm flag after the match has passed
    wr(5'h14, 32'h0000_0008);
    settle();
    rd(5'h14, v);
    chk("R9 alarm cleared", v, 32'h0);
    chk("R8 irq drops with flag", {31'b0, irq}, 32'h0);
    chk("R8 wake drops with flag", {31'b0, wake}, 32'h0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule